// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Select

This block sits beside the execute stage of a five-stage in-order pipeline. It compares the two source register numbers of the instruction now entering execute with the destination register numbers held by the two later stages. From those comparisons it forms one 2-bit select code for each ALU operand. Each code steers an operand mux, which lies outside this block, to one of three places: the register file read value, the ALU result waiting in the memory stage, or the value about to be written back.

With these selects, an arithmetic instruction can consume the result of the instruction directly ahead of it without any stall. The same holds for a result two instructions back. A producer three instructions back needs no forwarding, because the register file writes in the first half of the cycle and reads in the second half.

The logic is purely combinational. The selects follow the inputs within the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: Each select uses the codes 2'b00 = register file, 2'b10 = memory-stage ALU result and 2'b01 = writeback value. The code 2'b11 never appears.
- R2: `sel_a` is 2'b10 when `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_a`.
- R3: `sel_b` is 2'b10 when `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_b`.
- R4: `sel_a` is 2'b01 when `wb_wen` is 1, `wb_dst` is nonzero and `wb_dst` equals `ex_src_a`, provided the R2 condition does not hold.
- R5: `sel_b` is 2'b01 when `wb_wen` is 1, `wb_dst` is nonzero and `wb_dst` equals `ex_src_b`, provided the R3 condition does not hold.
- R6: When both stages match the same operand, the memory stage wins (code 2'b10), because it holds the newer result.
- R7: A source register number of 0 always gives the register-file code 2'b00.
- R8: A stage whose write enable is 0 never causes forwarding, whatever its destination number. With both enables at 0, both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_ADDR_W | First source register number of the execute-stage instruction |
| ex_src_b | input | REG_ADDR_W | Second source register number of the execute-stage instruction |
| mem_dst | input | REG_ADDR_W | Destination register held in the memory-stage pipeline register |
| mem_wen | input | 1 | Register write enable of the memory-stage instruction |
| wb_dst | input | REG_ADDR_W | Destination register held in the writeback-stage pipeline register |
| wb_wen | input | 1 | Register write enable of the writeback-stage instruction |
| sel_a | output | 2 | Source select for the first ALU operand |
| sel_b | output | 2 | Source select for the second ALU operand |

## Verification
The assertions assume every input is a known 0 or 1 when they are evaluated. They are skipped while any input still holds X. They also assume the two operands are judged independently, so a property on `sel_a` looks only at `ex_src_a` and the stage fields. The bench keeps within these assumptions: it drives every input from a task at the falling clock edge, with no X after the first drive. It sweeps every combination of sources, destinations and enables over a 3-bit register number, so that register 0, double matches and disabled stages all occur.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  // the newer stage wins; the older one is used only when the newer misses
  function automatic fwd_sel_e pick_source(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SEL_MEM;
    else if (wb_hit) return SEL_WB;
    else             return SEL_RF;
  endfunction
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] src,
  input  logic [REG_ADDR_W-1:0] dst,
  input  logic                  wen,
  output logic                  hit
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  function automatic logic producer_hit(input logic [REG_ADDR_W-1:0] s,
                                        input logic [REG_ADDR_W-1:0] d,
                                        input logic we);
    return we && (d != ZERO_REG) && (d == s);
  endfunction

  assign hit = producer_hit(src, dst, wen);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] src,
  input  logic [REG_ADDR_W-1:0] mem_dst,
  input  logic                  mem_wen,
  input  logic [REG_ADDR_W-1:0] wb_dst,
  input  logic                  wb_wen,
  output logic                  mem_hit,
  output logic                  wb_hit,
  output logic [1:0]            sel
);
  import fwd_pkg::*;

  fwd_match #(.REG_ADDR_W(REG_ADDR_W)) u_mem_cmp (
    .src(src), .dst(mem_dst), .wen(mem_wen), .hit(mem_hit)
  );

  fwd_match #(.REG_ADDR_W(REG_ADDR_W)) u_wb_cmp (
    .src(src), .dst(wb_dst), .wen(wb_wen), .hit(wb_hit)
  );

  fwd_sel_e choice;
  always_comb choice = pick_source(mem_hit, wb_hit);
  assign sel = choice;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] ex_src_a,
  input  logic [REG_ADDR_W-1:0] ex_src_b,
  input  logic [REG_ADDR_W-1:0] mem_dst,
  input  logic                  mem_wen,
  input  logic [REG_ADDR_W-1:0] wb_dst,
  input  logic                  wb_wen,
  output logic [1:0]            sel_a,
  output logic [1:0]            sel_b
);
  localparam int N_OPS = 2;

  logic [REG_ADDR_W-1:0] op_src [N_OPS];
  logic [1:0]            op_sel [N_OPS];
  // per-operand match events, named for observation
  logic [N_OPS-1:0]      mem_hit_vec;
  logic [N_OPS-1:0]      wb_hit_vec;

  assign op_src[0] = ex_src_a;
  assign op_src[1] = ex_src_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_operand_sel #(.REG_ADDR_W(REG_ADDR_W)) u_sel (
      .src     (op_src[g]),
      .mem_dst (mem_dst),
      .mem_wen (mem_wen),
      .wb_dst  (wb_dst),
      .wb_wen  (wb_wen),
      .mem_hit (mem_hit_vec[g]),
      .wb_hit  (wb_hit_vec[g]),
      .sel     (op_sel[g])
    );
  end

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_ADDR_W = 5
) (
  input logic [REG_ADDR_W-1:0] ex_src_a,
  input logic [REG_ADDR_W-1:0] ex_src_b,
  input logic [REG_ADDR_W-1:0] mem_dst,
  input logic                  mem_wen,
  input logic [REG_ADDR_W-1:0] wb_dst,
  input logic                  wb_wen,
  input logic [1:0]            sel_a,
  input logic [1:0]            sel_b
);
  logic known;
  assign known = !$isunknown({ex_src_a, ex_src_b, mem_dst, mem_wen, wb_dst, wb_wen});

  always_comb begin
    if (known) begin
      // R1: the unused code never appears
      a_r1_legal_code: assert (sel_a != 2'b11 && sel_b != 2'b11);
      // R2, R6: memory-stage select on A implies a real producer there
      a_r2_mem_a_valid: assert (sel_a != 2'b10 || (mem_wen && mem_dst == ex_src_a));
      // R3, R6: memory-stage select on B implies a real producer there
      a_r3_mem_b_valid: assert (sel_b != 2'b10 || (mem_wen && mem_dst == ex_src_b));
      // R4: writeback select on A only when the newer stage misses
      a_r4_wb_a_valid: assert (sel_a != 2'b01 ||
                               (wb_wen && wb_dst == ex_src_a && !(mem_wen && mem_dst == ex_src_a)));
      // R5: writeback select on B only when the newer stage misses
      a_r5_wb_b_valid: assert (sel_b != 2'b01 ||
                               (wb_wen && wb_dst == ex_src_b && !(mem_wen && mem_dst == ex_src_b)));
      // R7: register 0 is never forwarded
      a_r7_zero_reg: assert ((ex_src_a != '0 || sel_a == 2'b00) && (ex_src_b != '0 || sel_b == 2'b00));
      // R8: no enabled producer, no forwarding
      a_r8_no_writer: assert (mem_wen || wb_wen || (sel_a == 2'b00 && sel_b == 2'b00));
    end
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (.*);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  localparam int W = 3;
  localparam int NREG = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
  logic         mem_wen, wb_wen;
  logic [1:0]   sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_unit #(.REG_ADDR_W(W)) uut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  // expected code built arithmetically: 2 for newer-stage hit, 1 for older-only hit
  function automatic int expect_code(int src, int md, int mw, int wd, int ww);
    int m, w;
    m = (mw == 1 && md == src && src > 0) ? 1 : 0;
    w = (ww == 1 && wd == src && src > 0) ? 1 : 0;
    return 2 * m + w * (1 - m);
  endfunction

  function automatic string tag_for(int src, int md, int mw, int wd, int ww, bit is_b);
    int m, w;
    m = (mw == 1 && md == src) ? 1 : 0;
    w = (ww == 1 && wd == src) ? 1 : 0;
    if (src == 0)           return "R7";
    if (m == 1 && w == 1)   return "R6";
    if (m == 1)             return is_b ? "R3" : "R2";
    if (w == 1)             return is_b ? "R5" : "R4";
    if (mw == 0 && ww == 0) return "R8";
    return "R1";
  endfunction

  task automatic check_one(string tag, logic [1:0] got, int exp);
    checks++;
    if (got !== exp[1:0] || got === 2'b11) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp[1:0]);
    end
  endtask

  task automatic apply(int sa, int sb, int md, int mw, int wd, int ww);
    @(negedge clk);
    ex_src_a = W'(sa); ex_src_b = W'(sb);
    mem_dst = W'(md);  mem_wen = mw[0];
    wb_dst = W'(wd);   wb_wen = ww[0];
    #2;
    check_one(tag_for(sa, md, mw, wd, ww, 1'b0), sel_a, expect_code(sa, md, mw, wd, ww));
    check_one(tag_for(sb, md, mw, wd, ww, 1'b1), sel_b, expect_code(sb, md, mw, wd, ww));
  endtask

  initial begin
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
    mem_wen = 1'b0; wb_wen = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // idle state: nothing forwarded (R8)
    #2;
    check_one("R8 idle", sel_a, 0);
    check_one("R8 idle", sel_b, 0);
    // directed: back-to-back dependence on A (R2), two-back on B (R5), both stages (R6)
    apply(2, 5, 2, 1, 5, 1);
    apply(3, 3, 3, 1, 3, 1);
    apply(0, 0, 0, 1, 0, 1);    // R7
    apply(4, 6, 4, 0, 6, 0);    // R8 disabled writers
    // exhaustive sweep: R1..R8
    for (int en = 0; en < 4; en++)
      for (int md = 0; md < NREG; md++)
        for (int wd = 0; wd < NREG; wd++)
          for (int sa = 0; sa < NREG; sa++)
            for (int sb = 0; sb < NREG; sb++)
              apply(sa, sb, md, en & 1, wd, en >> 1);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule